// File: doc/BRIEF.md
# Latency-Aligned Double-Rate Burst Write Capture

This block sits on the device side of a low-latency DRAM-style command interface. It decodes a write command from four active-low strobes. In the same cycle it latches the full address, the bank number, a two-bit half-burst mask and the burst length. The request then waits in a shift pipeline for a programmable number of cycles. After that the block takes burst data from two data lanes, one holding the beat that arrives with the rising clock and one holding the beat that arrives with the falling clock. Both lanes are sampled on the rising clock, so the whole design runs on a single clock. The accepted words go into a small banked storage array.

A read command returns one stored word a cycle later. Reads exist so that the write-to-read turnaround can be exercised and the stored data can be checked. A read always sees storage as it was before the writes of its own clock edge. A pipeline entry holds everything a burst needs, so write commands may be issued on consecutive cycles. If a new burst would capture data on a cycle that the tail of the previous burst still occupies, the block raises a one-cycle flag.

Top module: `lat_wr_capture`

## Requirements
- R1: A command is decoded on the rising clock from cs_n, as_n, we_n and ref_n. cs_n=0, as_n=0, ref_n=1 and we_n=0 is a write. The same with we_n=1 is a read. Any other combination writes nothing and produces no read response.
- R2: For a write command at rising edge T with latency L, the first lane pair is captured and stored at rising edge T+L. A read at edge T+L or earlier returns the old contents. A read at edge T+L+1 returns the new data. Lane values on any other cycle are not stored.
- R3: cfg_wl is sampled when the burst reaches capture and must be held steady while writes are pending. Values 1 to MAX_WL give that latency, and a value of 0 behaves as 1.
- R4: cfg_bl4 is sampled with the write command (0 = burst of 2, 1 = burst of 4). A burst of 2 is one lane pair: rise = beat 0, fall = beat 1. A burst of 4 uses lane pairs on two consecutive rising edges: beats 0 and 1 on the first, beats 2 and 3 on the second.
- R5: Beat i goes to the address whose low log2(BL) bits equal (base + i) mod BL. The higher bits are those of the command address, so the burst wraps inside its aligned group.
- R6: dmask is sampled with the write command. A high bit 0 suppresses the first half of the burst: beat 0 for a burst of 2, beats 0 and 1 for a burst of 4. A high bit 1 suppresses the second half: beat 1, or beats 2 and 3.
- R7: Each bank holds 2^COL_W words. Bit j of a word's index is the XOR of every address bit whose position mod COL_W equals j, so aliasing addresses share a word. All words reset to zero.
- R8: A read at edge T sets rd_valid for the cycle after T. rd_data then holds the addressed word as it stood before the writes of edge T. rd_data holds its value between reads.
- R9: If the first lane pair of one burst is due on the same edge as the second pair of an earlier burst of 4, the newer pair is stored and the older pair is dropped. wr_clash is high for the cycle after that edge.
- R10: Write commands on consecutive cycles all land at their own latency, with no loss while pipeline entries overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write enable, low selects write |
| ref_n | input | 1 | Refresh strobe, must be high for read or write |
| addr | input | 20 | Burst base address |
| bank | input | 3 | Bank number |
| dmask | input | 2 | Half-burst suppress bits, sampled with the command |
| cfg_wl | input | 3 | Write latency in cycles |
| cfg_bl4 | input | 1 | 1 = burst of 4, 0 = burst of 2 |
| dq_rise | input | 16 | Beat that arrived with the rising edge |
| dq_fall | input | 16 | Beat that arrived with the following falling edge |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 16 | Read response word |
| wr_clash | output | 1 | One-cycle pulse on overlapping bursts |

## Verification
The bench drives reads on the edges just before, exactly at and just after the capture edge. A design with the latency off by one cycle, or one that forwards uncommitted write data to reads, returns the wrong word there. Bursts of 4 are started at base addresses with low bits 2 and 3. A design that carries into the higher address bits instead of wrapping writes outside the aligned group. All four mask values are applied to both burst lengths, and a design that masks per beat or swaps the halves leaves stale or wrong words. Back-to-back bursts of 4 force the clash case: the flag must pulse and the older tail must vanish. Bursts of 2 on every cycle must all land, and latency values of 0, 1 and 7 cover the ends of the shift pipeline.

// File: rtl/wrcap_pkg.sv
package wrcap_pkg;
  localparam int ADDR_W = 20;
  localparam int BANK_W = 3;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] a;
    logic [BANK_W-1:0] b;
    logic [1:0]        m;
    logic              bl4;
  } wr_ent_t;

  // address of beat idx of a burst, wrapping inside the aligned group
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [1:0] idx,
                                                  input logic bl4);
    logic [ADDR_W-1:0] r;
    r = base;
    if (bl4) r[1:0] = base[1:0] + idx;
    else     r[0]   = base[0] ^ idx[0];
    return r;
  endfunction
endpackage

// File: rtl/wrcap_cmd_dec.sv
module wrcap_cmd_dec (
  input  logic cs_n,
  input  logic as_n,
  input  logic we_n,
  input  logic ref_n,
  output logic is_wr,
  output logic is_rd
);
  logic sel;
  assign sel   = !cs_n && !as_n && ref_n;
  assign is_wr = sel && !we_n;
  assign is_rd = sel && we_n;
endmodule

// File: rtl/wrcap_lat_pipe.sv
module wrcap_lat_pipe
  import wrcap_pkg::*;
#(
  parameter  int MAX_WL = 7,
  localparam int WL_W   = $clog2(MAX_WL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_ent_t         ent_i,
  input  logic [WL_W-1:0] wl_i,
  output wr_ent_t         first_o,
  output wr_ent_t         second_o,
  output logic            clash_o
);
  wr_ent_t         stg [MAX_WL];
  wr_ent_t         sec_q;
  logic [WL_W-1:0] tap_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= ent_i;
  end

  generate
    for (genvar g = 1; g < MAX_WL; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  always_comb begin
    if (wl_i == '0)                 tap_idx = '0;
    else if (int'(wl_i) > MAX_WL)   tap_idx = WL_W'(MAX_WL - 1);
    else                            tap_idx = wl_i - 1'b1;
  end

  assign first_o = stg[tap_idx];

  // tail of a burst of 4 waits one more edge
  always_ff @(posedge clk) begin
    if (!rst_n)                       sec_q <= '0;
    else if (first_o.v && first_o.bl4) sec_q <= first_o;
    else                              sec_q <= '0;
  end

  assign second_o = sec_q;
  assign clash_o  = first_o.v && sec_q.v;

  // R4: a tail lives for exactly one edge unless a new burst of 4 refills it
  p_tail_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (second_o.v && !(first_o.v && first_o.bl4)) |=> !second_o.v);
endmodule

// File: rtl/wrcap_store.sv
module wrcap_store #(
  parameter  int DW     = 16,
  parameter  int COL_W  = 4,
  parameter  int BANK_W = 3,
  localparam int IDX_W  = BANK_W + COL_W,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_r,
  input  logic              we_f,
  input  logic [BANK_W-1:0] wbank,
  input  logic [COL_W-1:0]  col_r,
  input  logic [COL_W-1:0]  col_f,
  input  logic [DW-1:0]     d_r,
  input  logic [DW-1:0]     d_f,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rbank,
  input  logic [COL_W-1:0]  rcol,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_r) mem[{wbank, col_r}] <= d_r;
      if (we_f) mem[{wbank, col_f}] <= d_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[{rbank, rcol}];
    end
  end

  // R5: the two lanes of one edge never target the same word
  p_lanes_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_r && we_f) |-> (col_r != col_f));

  // R8: the response word only moves on a read
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lat_wr_capture.sv
module lat_wr_capture
  import wrcap_pkg::*;
#(
  parameter  int DW     = 16,
  parameter  int COL_W  = 4,
  parameter  int MAX_WL = 7,
  localparam int WL_W   = $clog2(MAX_WL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              we_n,
  input  logic              ref_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        dmask,
  input  logic [WL_W-1:0]   cfg_wl,
  input  logic              cfg_bl4,
  input  logic [DW-1:0]     dq_rise,
  input  logic [DW-1:0]     dq_fall,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              wr_clash
);
  // fold the full address into a word index
  function automatic logic [COL_W-1:0] fold_col(input logic [ADDR_W-1:0] a);
    logic [COL_W-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) r[i % COL_W] = r[i % COL_W] ^ a[i];
    return r;
  endfunction

  logic             is_wr, is_rd;
  wr_ent_t          ent_in, first_e, second_e, act;
  logic             clash;
  logic             half;
  logic [1:0]       idx_r, idx_f;
  logic             blk_r, blk_f;
  logic             we_r, we_f;
  logic [COL_W-1:0] col_r, col_f, rcol;

  wrcap_cmd_dec u_dec (
    .cs_n (cs_n), .as_n (as_n), .we_n (we_n), .ref_n (ref_n),
    .is_wr(is_wr), .is_rd(is_rd)
  );

  always_comb begin
    ent_in.v   = is_wr;
    ent_in.a   = addr;
    ent_in.b   = bank;
    ent_in.m   = dmask;
    ent_in.bl4 = cfg_bl4;
  end

  wrcap_lat_pipe #(.MAX_WL(MAX_WL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ent_i(ent_in), .wl_i(cfg_wl),
    .first_o(first_e), .second_o(second_e), .clash_o(clash)
  );

  // a new first pair wins over an old tail
  always_comb begin
    half  = !first_e.v;
    act   = first_e.v ? first_e : second_e;
    idx_r = half ? 2'd2 : 2'd0;
    idx_f = half ? 2'd3 : 2'd1;
    blk_r = act.bl4 ? act.m[half] : act.m[0];
    blk_f = act.bl4 ? act.m[half] : act.m[1];
    we_r  = act.v && !blk_r;
    we_f  = act.v && !blk_f;
    col_r = fold_col(beat_addr(act.a, idx_r, act.bl4));
    col_f = fold_col(beat_addr(act.a, idx_f, act.bl4));
    rcol  = fold_col(addr);
  end

  wrcap_store #(.DW(DW), .COL_W(COL_W), .BANK_W(BANK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_r(we_r), .we_f(we_f), .wbank(act.b), .col_r(col_r), .col_f(col_f),
    .d_r(dq_rise), .d_f(dq_fall),
    .rd_en(is_rd), .rbank(bank), .rcol(rcol),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wr_clash <= 1'b0;
    else        wr_clash <= clash;
  end

  // R8: a response follows a read command on the pins
  p_rd_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!cs_n && !as_n && we_n && ref_n));

  // R9: a clash pulse implies a tail was waiting on the previous edge
  p_clash_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clash |-> $past(second_e.v && second_e.bl4));
endmodule

// File: tb/lat_wr_capture_tb_top.sv
`timescale 1ns/100ps
module lat_wr_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, as_n = 1'b1, we_n = 1'b1, ref_n = 1'b1;
  logic [19:0] addr = '0;
  logic [2:0]  bank = '0;
  logic [1:0]  dmask = '0;
  logic [2:0]  cfg_wl = 3'd3;
  logic        cfg_bl4 = 1'b0;
  logic [15:0] dq_rise = '0, dq_fall = '0;
  logic        rd_valid, wr_clash;
  logic [15:0] rd_data;

  lat_wr_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .we_n(we_n), .ref_n(ref_n),
    .addr(addr), .bank(bank), .dmask(dmask), .cfg_wl(cfg_wl), .cfg_bl4(cfg_bl4),
    .dq_rise(dq_rise), .dq_fall(dq_fall),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_clash(wr_clash)
  );

  always #2.5 clk = ~clk;

  int unsigned mem_m [8][16];
  bit f_v [16]; int f_a [16]; int f_b [16]; int f_m [16]; bit f_4 [16];
  bit s_v [16]; int s_a [16]; int s_b [16]; int s_m [16];
  int    cyc = 0;
  bit    exp_rv, exp_err;
  int    exp_rd;
  string tag = "R7";
  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;

  function automatic int fold(int a);
    int r = 0;
    for (int i = 0; i < 20; i++) if ((a >> i) & 1) r = r ^ (1 << (i % 4));
    return r;
  endfunction

  function automatic int baddr(int base, int i, bit b4);
    int m = b4 ? 3 : 1;
    return (base & ~m) | ((base + i) & m);
  endfunction

  task automatic chk(string t, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", t, what, act, expv, cyc);
    end
  endtask

  // reference behaviour for the coming rising edge
  task automatic model_edge();
    bit rd, wr;
    int s, t, w;
    rd = !cs_n && !as_n && we_n && ref_n;
    wr = !cs_n && !as_n && !we_n && ref_n;
    exp_rv = rd;
    if (rd) exp_rd = int'(mem_m[bank][fold(int'(addr))]);
    s = cyc % 16;
    exp_err = f_v[s] && s_v[s];
    if (f_v[s]) begin
      s_v[s] = 0;
      if (!f_m[s][0])
        mem_m[f_b[s]][fold(baddr(f_a[s], 0, f_4[s]))] = dq_rise;
      if (!(f_4[s] ? f_m[s][0] : f_m[s][1]))
        mem_m[f_b[s]][fold(baddr(f_a[s], 1, f_4[s]))] = dq_fall;
      if (f_4[s]) begin
        t = (cyc + 1) % 16;
        s_v[t] = 1; s_a[t] = f_a[s]; s_b[t] = f_b[s]; s_m[t] = f_m[s];
      end
      f_v[s] = 0;
    end else if (s_v[s]) begin
      if (!s_m[s][1]) begin
        mem_m[s_b[s]][fold(baddr(s_a[s], 2, 1))] = dq_rise;
        mem_m[s_b[s]][fold(baddr(s_a[s], 3, 1))] = dq_fall;
      end
      s_v[s] = 0;
    end
    if (wr) begin
      w = (cfg_wl == 0) ? 1 : int'(cfg_wl);
      t = (cyc + w) % 16;
      f_v[t] = 1; f_a[t] = int'(addr); f_b[t] = int'(bank);
      f_m[t] = int'(dmask); f_4[t] = cfg_bl4;
    end
    cyc++;
  endtask

  task automatic tick();
    dq_rise = 16'($urandom);
    dq_fall = 16'($urandom);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("R8", "rd_valid", int'(rd_valid), int'(exp_rv));
    chk("R9", "wr_clash", int'(wr_clash), int'(exp_err));
    if (exp_rv) chk(tag, "rd_data", int'(rd_data), exp_rd);
  endtask

  task automatic nop();
    cs_n = 1; as_n = 1; we_n = 1; ref_n = 1;
  endtask

  task automatic wr(int a, int b, int m, bit b4);
    cs_n = 0; as_n = 0; we_n = 0; ref_n = 1;
    addr = 20'(a); bank = 3'(b); dmask = 2'(m); cfg_bl4 = b4;
    tick(); nop();
  endtask

  task automatic rd(int a, int b);
    cs_n = 0; as_n = 0; we_n = 1; ref_n = 1;
    addr = 20'(a); bank = 3'(b);
    tick(); nop();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd_group(int a, int b);
    for (int i = 0; i < 4; i++) rd(baddr(a, i, 1), b);
  endtask

  initial begin
    for (int b = 0; b < 8; b++) for (int c = 0; c < 16; c++) mem_m[b][c] = 0;
    for (int i = 0; i < 16; i++) begin f_v[i] = 0; s_v[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7: reset state
    chk("R7", "rd_valid after reset", int'(rd_valid), 0);
    chk("R7", "wr_clash after reset", int'(wr_clash), 0);
    tag = "R7"; rd(9, 5); rd(20'hABCDE, 7);

    // R1: near-miss strobe patterns store nothing
    tag = "R1";
    addr = 20'h00040; bank = 1; dmask = 0; cfg_bl4 = 1;
    cs_n = 1; as_n = 0; we_n = 0; ref_n = 1; tick();
    cs_n = 0; as_n = 1; we_n = 0; ref_n = 1; tick();
    cs_n = 0; as_n = 0; we_n = 0; ref_n = 0; tick();
    cs_n = 0; as_n = 0; we_n = 1; ref_n = 0; tick();
    nop(); idle(10); rd_group(20'h00040, 1);

    // R2: reads before, at and after the capture edge
    tag = "R2"; cfg_wl = 3;
    wr(20'h00010, 2, 0, 0);
    rd(20'h00010, 2); rd(20'h00010, 2); rd(20'h00010, 2); rd(20'h00010, 2);
    rd(20'h00011, 2); idle(4);

    // R4 / R5: bursts of 4 at every offset, burst of 2 at odd base
    tag = "R5";
    for (int o = 0; o < 4; o++) begin
      wr(20'h00020 + o, 3, 0, 1); idle(6); rd_group(20'h00020, 3);
    end
    tag = "R4";
    wr(20'h00033, 3, 0, 0); idle(5); rd(20'h00032, 3); rd(20'h00033, 3);

    // R6: all mask values, both lengths
    tag = "R6";
    for (int m = 0; m < 4; m++) begin
      wr(20'h00050, 4, 0, 1); idle(6);
      wr(20'h00051, 4, m, 1); idle(6); rd_group(20'h00050, 4);
      wr(20'h00060, 4, 0, 0); idle(5);
      wr(20'h00060, 4, m, 0); idle(5); rd(20'h00060, 4); rd(20'h00061, 4);
    end

    // R3: latency ends and zero
    tag = "R3";
    for (int w = 0; w < 3; w++) begin
      cfg_wl = (w == 0) ? 3'd0 : (w == 1) ? 3'd1 : 3'd7;
      wr(20'h00070, 5, 0, 1);
      rd(20'h00070, 5); rd(20'h00071, 5); rd(20'h00072, 5);
      idle(8); rd_group(20'h00070, 5);
    end

    // R9: clashing bursts, then a non-clashing spacing
    tag = "R9"; cfg_wl = 3;
    wr(20'h00080, 6, 0, 1); wr(20'h00084, 6, 0, 1); idle(6);
    rd_group(20'h00080, 6); rd_group(20'h00084, 6);
    wr(20'h00088, 6, 0, 1); idle(1); wr(20'h0008C, 6, 0, 1); idle(6);
    rd_group(20'h00088, 6); rd_group(20'h0008C, 6);

    // R10: a write every cycle
    tag = "R10"; cfg_wl = 4;
    for (int i = 0; i < 6; i++) wr(20'h00090 + 2 * i, 0, 0, 0);
    idle(6);
    for (int i = 0; i < 12; i++) rd(20'h00090 + i, 0);

    // mixed traffic per latency setting
    tag = "R8";
    for (int ph = 0; ph < 4; ph++) begin
      cfg_wl = 3'(ph * 2 + 1);
      for (int i = 0; i < 150; i++) begin
        int k = $urandom_range(0, 9);
        int a = $urandom_range(0, 20'hFFFFF);
        if (k < 4)      wr(a, $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 1));
        else if (k < 8) rd(a, $urandom_range(0, 7));
        else            tick();
      end
      idle(10);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule